// File: doc/BRIEF.md
# DMA Event Capture and Enable Unit

This block sits in front of the transfer engine of a 16-channel DMA controller. Every channel has one synchronization event input. The block brings each input through a two-flop synchronizer and looks for a rising edge. Each detected edge is latched into a pending register. A pending bit stays set until software removes it or the transfer engine takes the request. Disabling a channel does not drop its event.

A separate enable register gates the pending bits. Among the channels that are both pending and enabled, the lowest-numbered one is offered to the transfer engine as a 4-bit index with a valid flag. When the engine raises ready, that pending bit clears on the same clock edge, and the next candidate is offered after it.

Software uses a 32-bit register port with a write strobe and a combinational read. Through it, software reads the pending and enable state, writes the enable mask, and forces pending bits on or off with write-one-to-set and write-one-to-clear registers.

Top module: `dma_evt_gate`

## Requirements
- R1: After reset, the pending and enable registers read zero and `req_valid_o` is low.
- R2: An event is taken only on a low-to-high transition of its input. The pending bit becomes visible three clock edges after the input rises: two synchronizer stages, then the latch. A level that stays high does not set the bit again after it has been cleared.
- R3: A detected event sets its pending bit whether or not its enable bit is set.
- R4: A write to offset 0x14 loads the enable mask from bits 15:0 of the write data, where 1 enables a channel and 0 disables it. A read of 0x14 returns the mask. Disabling a channel leaves its pending bit untouched.
- R5: Setting the enable bit of a channel that is already pending raises a request on the next cycle, with no new edge needed.
- R6: Writing 1 to a bit at offset 0x18 clears that pending bit. Writing 0 leaves the bit unchanged. Reads of 0x18 return zero.
- R7: Writing 1 to a bit at offset 0x1C sets that pending bit, as a hardware edge would. Reads of 0x1C return zero.
- R8: If a bit is set (by an edge or by the set register) on the same edge that clears it (by the clear register or by an accept), the bit ends up set.
- R9: `req_valid_o` is high exactly when some channel is both pending and enabled. `req_chan_o` then gives the lowest such channel number as an unsigned binary index.
- R10: On a clock edge where `req_valid_o` and `req_ready_i` are both high, the pending bit of the channel in `req_chan_o` is cleared.
- R11: The pending register at offset 0x10 is read-only, and writes to it have no effect. Bits 31:16 of every read are zero, and reads of any offset other than 0x10 and 0x14 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Asynchronous event inputs, one per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| req_valid_o | output | 1 | A pending, enabled channel is offered |
| req_chan_o | output | 4 | Index of the offered channel |
| req_ready_i | input | 1 | Transfer engine accepts the offered channel |

## Verification
The assertions treat `req_ready_i` as meaningful only while `req_valid_o` is high. They also expect every write to carry a byte offset that is either one of the four decoded offsets or is meant to be ignored.

The stimulus changes all inputs one nanosecond after the rising edge. The behavioural model therefore sees stable values, and the synchronizer delay is deterministic. Event pulses are held for several cycles in the directed phases and are random in the soak phase. The model samples the inputs exactly as the flops do, so short pulses are predicted exactly as well.

// File: rtl/dma_evt_gate.sv
module dma_evt_gate #(
  parameter int NCH    = 16,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter logic [AW-1:0] OFF_PEND = 8'h10,
  parameter logic [AW-1:0] OFF_EN   = 8'h14,
  parameter logic [AW-1:0] OFF_CLR  = 8'h18,
  parameter logic [AW-1:0] OFF_SET  = 8'h1C
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         evt_i,
  input  logic                   reg_we_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic [DW-1:0]          reg_wdata_i,
  output logic [DW-1:0]          reg_rdata_o,
  output logic                   req_valid_o,
  output logic [$clog2(NCH)-1:0] req_chan_o,
  input  logic                   req_ready_i
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0] sync1_q, sync2_q, sync3_q, pend_q, en_q;
  logic [NCH-1:0] edge_det, elig, grant, clr_mask, set_mask;
  logic [NCH-1:0] lo_mask;
  logic           set_hit, clr_hit, en_hit;

  assign edge_det = sync2_q & ~sync3_q;
  assign set_hit  = reg_we_i && (reg_addr_i == OFF_SET);
  assign clr_hit  = reg_we_i && (reg_addr_i == OFF_CLR);
  assign en_hit   = reg_we_i && (reg_addr_i == OFF_EN);
  assign set_mask = set_hit ? reg_wdata_i[NCH-1:0] : '0;
  assign clr_mask = clr_hit ? reg_wdata_i[NCH-1:0] : '0;
  assign elig     = pend_q & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      sync3_q <= '0;
    end else begin
      sync1_q <= evt_i;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
    end
  end

  always_comb begin
    req_valid_o = 1'b0;
    req_chan_o  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        req_valid_o = 1'b1;
        req_chan_o  = IW'(i);
      end
    end
  end

  always_comb begin
    grant = '0;
    if (req_valid_o && req_ready_i) grant[req_chan_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask & ~grant) | edge_det | set_mask;
      if (en_hit) en_q <= reg_wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == OFF_PEND)    reg_rdata_o[NCH-1:0] = pend_q;
    else if (reg_addr_i == OFF_EN) reg_rdata_o[NCH-1:0] = en_q;
  end

  always_comb begin
    lo_mask = '0;
    for (int i = 0; i < NCH; i++)
      if (IW'(i) < req_chan_o) lo_mask[i] = 1'b1;
  end

  p_lowest_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (pend_q[req_chan_o] && en_q[req_chan_o] && ((pend_q & en_q & lo_mask) == '0)));

  p_set_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit |=> ((pend_q & $past(reg_wdata_i[NCH-1:0])) == $past(reg_wdata_i[NCH-1:0])));

  p_edge_latched_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_det != '0) |=> ((pend_q & $past(edge_det)) == $past(edge_det)));

  p_never_lost_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_hit && !(req_valid_o && req_ready_i)) |=> (($past(pend_q) & ~pend_q) == '0));

  p_accept_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i && !set_hit && !edge_det[req_chan_o]) |=> !pend_q[$past(req_chan_o)]);
endmodule

// File: tb/dma_evt_gate_tb.sv
`timescale 1ns/1ps
module dma_evt_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h10;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [3:0]  rchan;
  logic        ready = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit running = 1'b0;

  always #2 clk = ~clk;

  dma_evt_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_valid_o(rvalid),
    .req_chan_o(rchan), .req_ready_i(ready));

  logic [15:0] m_pend, m_en;
  logic [15:0] hist[$];

  function automatic int m_pick(input logic [15:0] p, input logic [15:0] e);
    for (int i = 0; i < 16; i++) if (p[i] && e[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0;
      m_en = '0;
      hist = '{16'h0, 16'h0, 16'h0};
    end else begin
      int sel;
      logic [15:0] nxt, edges;
      sel = m_pick(m_pend, m_en);
      edges = hist[1] & ~hist[2];
      nxt = m_pend;
      if (we && addr == 8'h18) nxt = nxt & ~wdata[15:0];
      if (sel >= 0 && ready) nxt[sel] = 1'b0;
      nxt = nxt | edges;
      if (we && addr == 8'h1C) nxt = nxt | wdata[15:0];
      if (we && addr == 8'h14) m_en = wdata[15:0];
      m_pend = nxt;
      hist.push_front(evt);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (running) begin
      int sel;
      logic [31:0] exp_rd;
      sel = m_pick(m_pend, m_en);
      exp_rd = (addr == 8'h10) ? {16'h0, m_pend} : (addr == 8'h14) ? {16'h0, m_en} : 32'h0;
      n_cmp++;
      if (rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s rdata@%h got %h exp %h", tag, addr, rdata, exp_rd);
      end
      n_cmp++;
      if (rvalid !== (sel >= 0)) begin
        n_bad++;
        $display("FAIL %s valid got %b exp %b", tag, rvalid, sel >= 0);
      end
      if (sel >= 0) begin
        n_cmp++;
        if (rchan !== 4'(sel)) begin
          n_bad++;
          $display("FAIL %s chan got %0d exp %0d", tag, rchan, sel);
        end
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; addr = 8'h10;
  endtask

  task automatic look(input logic [7:0] a);
    addr = a;
    step();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired in phase %s", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    running = 1'b1;
    tag = "R1 reset";
    look(8'h10); look(8'h14);

    tag = "R3 capture while disabled";
    evt[3] = 1'b1;
    step(6);
    tag = "R2 level hold no retrigger";
    wr(8'h18, 32'h0000_0008);
    step(5);
    wr(8'h1C, 32'h0000_0008);

    tag = "R4 enable then disable";
    wr(8'h14, 32'h0000_0008);
    step(2);
    wr(8'h14, 32'h0000_0000);
    look(8'h14); look(8'h10);
    tag = "R5 reenable pending";
    wr(8'h14, 32'hFFFF_0008);
    look(8'h14); step(2);

    tag = "R10 accept clears";
    ready = 1'b1; step(); ready = 1'b0;
    step(2);
    evt[3] = 1'b0;
    step(3);

    tag = "R7 set register";
    wr(8'h1C, 32'h0000_00F0);
    look(8'h1C);
    wr(8'h14, 32'h0000_FFFF);
    tag = "R9 priority order";
    step(2);
    ready = 1'b1; step(4); ready = 1'b0;
    step(2);

    tag = "R6 clear register";
    wr(8'h1C, 32'h0000_0303);
    wr(8'h18, 32'h0000_0000);
    look(8'h10);
    wr(8'h18, 32'h0000_0101);
    look(8'h18); look(8'h10);
    wr(8'h18, 32'h0000_FFFF);

    tag = "R8 edge beats clear";
    wr(8'h14, 32'h0000_0000);
    evt[9] = 1'b1;
    wr(8'h18, 32'h0000_0200);
    wr(8'h18, 32'h0000_0200);
    wr(8'h18, 32'h0000_0200);
    look(8'h10); look(8'h10);
    tag = "R8 set beats accept";
    wr(8'h14, 32'h0000_0200);
    ready = 1'b1;
    wr(8'h1C, 32'h0000_0200);
    ready = 1'b0;
    step(2);
    evt[9] = 1'b0;
    wr(8'h18, 32'h0000_FFFF);

    tag = "R11 pend read-only";
    wr(8'h10, 32'hFFFF_FFFF);
    look(8'h10); look(8'h04); look(8'h18); look(8'h1C); look(8'hFC);

    tag = "R2 R9 R10 random soak";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      evt = evt ^ (($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0);
      ready = ($urandom_range(0, 2) == 0);
      if (r == 0) wr(8'h14, $urandom);
      else if (r == 1) wr(8'h18, $urandom);
      else if (r == 2) wr(8'h1C, $urandom & 32'h0000_1111);
      else if (r == 3) wr(8'h10, $urandom);
      else begin
        addr = ($urandom_range(0, 1) == 0) ? 8'h10 : 8'h14;
        step();
      end
    end
    ready = 1'b0;
    step(4);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule